// File: doc/BRIEF.md
# Table-Based System Clock Divider

This block derives four related system clocks from a single full-rate PLL clock: a core clock (channel 0), a high-speed bus clock (channel 1), a low-speed bus clock (channel 2) and a memory clock (channel 3). Every channel counts cycles of the same PLL clock. Each channel's division ratio is chosen by a 4-bit code, and the code selects an entry from a fixed, non-uniform ratio table. Codes past the end of the table are clamped to the largest ratio.

Software writes one control word through a plain write strobe. The word carries the four codes and a change-enable flag. Each channel reloads its ratio only at the end of a complete output period, and only while change-enable is set. Written codes can therefore be staged with the flag clear and applied later, and no channel ever emits a shortened period.

Each channel drives a clock level and a one-cycle enable strobe. For even ratios the level is a 50% duty clock. For odd ratios the level repeats the strobe pattern.

Top module: `sysclk_ratio_div`

## Requirements
- R1: After reset every channel runs at ratio 1: all strobes and all clock levels are high in every cycle until a new ratio is applied.
- R2: Codes 0 through 9 select ratios 1, 2, 3, 4, 6, 8, 12, 16, 24 and 32 respectively.
- R3: Any code from 10 to 15 selects a ratio of 32.
- R4: In the control word, the channel 0 code occupies bits 3:0, channel 1 bits 7:4, channel 2 bits 11:8, channel 3 bits 15:12, and bit 22 is change-enable. All other bits have no effect.
- R5: While the stored change-enable bit is 0, newly written codes are held pending and every channel keeps its current ratio.
- R6: A new ratio takes effect only after the final cycle of the period currently in progress. The period in flight always completes at its old length.
- R7: A channel with ratio N asserts its strobe for exactly one cycle, the last one, of every N-cycle period.
- R8: For an even ratio N, the clock level is high for the first N/2 cycles of each period and low for the remaining N/2.
- R9: For an odd ratio, the clock level equals the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pll | input | 1 | Full-rate PLL clock shared by all channels |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word (codes and change-enable) |
| div_clk | output | 4 | Clock level per channel (0 core, 1 high-speed bus, 2 low-speed bus, 3 memory) |
| div_stb | output | 4 | One-cycle enable strobe per channel, high in the last cycle of each period |

## Verification
The bench builds the block with its default parameters: four channels, 4-bit codes, change-enable at bit 22 and a largest ratio of 32. With these values every table entry, every clamped code and full 32-cycle periods are reachable within a short run. Period lengths are measured on each channel with distinct codes at the same time, which shows each field reaches its own channel. A mid-period ratio change with 32 cycles still to run checks that the period in flight completes at its old length.

// File: rtl/sysclk_div_pkg.sv
package sysclk_div_pkg;
  localparam int unsigned NUM_CH       = 4;
  localparam int unsigned CODE_W       = 4;
  localparam int unsigned FIELD_STRIDE = 4;
  localparam int unsigned CHG_BIT      = 22;
  localparam int unsigned WORD_W       = 32;
  localparam int unsigned MAX_RATIO    = 32;
  localparam int unsigned RATIO_W      = $clog2(MAX_RATIO + 1);
  localparam int unsigned CNT_W        = $clog2(MAX_RATIO);

  typedef logic [RATIO_W-1:0] ratio_t;
  typedef logic [CNT_W-1:0]   count_t;
  typedef logic [CODE_W-1:0]  code_t;

  function automatic ratio_t code_to_ratio(input code_t code);
    case (code)
      code_t'(0): code_to_ratio = ratio_t'(1);
      code_t'(1): code_to_ratio = ratio_t'(2);
      code_t'(2): code_to_ratio = ratio_t'(3);
      code_t'(3): code_to_ratio = ratio_t'(4);
      code_t'(4): code_to_ratio = ratio_t'(6);
      code_t'(5): code_to_ratio = ratio_t'(8);
      code_t'(6): code_to_ratio = ratio_t'(12);
      code_t'(7): code_to_ratio = ratio_t'(16);
      code_t'(8): code_to_ratio = ratio_t'(24);
      default:    code_to_ratio = ratio_t'(MAX_RATIO);
    endcase
  endfunction
endpackage

// File: rtl/sysclk_div_ctrl.sv
module sysclk_div_ctrl
  import sysclk_div_pkg::*;
#(
  parameter int unsigned N_CH   = NUM_CH,
  parameter int unsigned W_WORD = WORD_W,
  parameter int unsigned STRIDE = FIELD_STRIDE,
  parameter int unsigned CHG    = CHG_BIT
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [W_WORD-1:0]      wr_data,
  output code_t                  code_o [N_CH],
  output logic                   chg_o
);
  code_t code_q [N_CH];
  logic  chg_q;
  logic  ctrl_unused;

  // Only the code fields and the change-enable bit are stored.
  assign ctrl_unused = ^wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(N_CH); i++) code_q[i] <= '0;
      chg_q <= 1'b0;
    end else if (wr_en) begin
      for (int i = 0; i < int'(N_CH); i++)
        code_q[i] <= wr_data[i*STRIDE +: CODE_W];
      chg_q <= wr_data[CHG];
    end
  end

  generate
    for (genvar g = 0; g < int'(N_CH); g++) begin : g_out
      assign code_o[g] = code_q[g];
    end
  endgenerate
  assign chg_o = chg_q;

  // R5
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(chg_q) && $stable(code_q[0]) && $stable(code_q[N_CH-1]));
endmodule

// File: rtl/sysclk_div_chan.sv
module sysclk_div_chan
  import sysclk_div_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  code_t code_i,
  input  logic  chg_i,
  output logic  div_clk_o,
  output logic  div_stb_o
);
  ratio_t ratio_q;
  count_t cnt_q;
  logic   last;
  ratio_t half;
  ratio_t cnt_ext;

  assign cnt_ext = {{(RATIO_W-CNT_W){1'b0}}, cnt_q};
  assign last    = (cnt_ext == ratio_q - ratio_t'(1));
  assign half    = ratio_q >> 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q <= ratio_t'(1);
      cnt_q   <= '0;
    end else if (last) begin
      cnt_q <= '0;
      if (chg_i) ratio_q <= code_to_ratio(code_i);
    end else begin
      cnt_q <= cnt_q + count_t'(1);
    end
  end

  assign div_stb_o = last;
  assign div_clk_o = ratio_q[0] ? last : (cnt_ext < half);

  // R6
  ratio_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ratio_q) |-> $past(last));
  // R7
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_ext < ratio_q);
  // R7
  stb_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_stb_o |=> cnt_q == '0);
  // R2
  ratio_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(ratio_q) || ratio_q == ratio_t'(3) || ratio_q == ratio_t'(6) ||
    ratio_q == ratio_t'(12) || ratio_q == ratio_t'(24));
  // R8
  even_tail_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_stb_o && !ratio_q[0]) |-> !div_clk_o);
endmodule

// File: rtl/sysclk_ratio_div.sv
module sysclk_ratio_div
  import sysclk_div_pkg::*;
(
  input  logic              clk_pll,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [NUM_CH-1:0] div_clk,
  output logic [NUM_CH-1:0] div_stb
);
  code_t code [NUM_CH];
  logic  chg;

  sysclk_div_ctrl #(
    .N_CH  (NUM_CH),
    .W_WORD(WORD_W),
    .STRIDE(FIELD_STRIDE),
    .CHG   (CHG_BIT)
  ) u_ctrl (
    .clk    (clk_pll),
    .rst_n  (rst_n),
    .wr_en  (cfg_wr),
    .wr_data(cfg_wdata),
    .code_o (code),
    .chg_o  (chg)
  );

  generate
    for (genvar g = 0; g < int'(NUM_CH); g++) begin : g_ch
      sysclk_div_chan u_chan (
        .clk      (clk_pll),
        .rst_n    (rst_n),
        .code_i   (code[g]),
        .chg_i    (chg),
        .div_clk_o(div_clk[g]),
        .div_stb_o(div_stb[g])
      );
    end
  endgenerate
endmodule

// File: tb/sysclk_ratio_div_tb.sv
`timescale 1ns/1ps
module sysclk_ratio_div_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [3:0]  div_clk, div_stb;

  int n_chk = 0, n_fail = 0;
  bit cmp_on = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sysclk_ratio_div u_dut (
    .clk_pll(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .div_clk(div_clk), .div_stb(div_stb)
  );

  // Ratio formula: odd code c -> 2^((c+1)/2), even code c>=2 -> 3*2^((c-2)/2).
  function automatic int ref_ratio(int c);
    if (c == 0) return 1;
    if (c >= 10) return 32;
    if (c % 2 == 1) return 1 << ((c + 1) / 2);
    return 3 * (1 << ((c - 2) / 2));
  endfunction

  function automatic logic [31:0] make_word(int c0, int c1, int c2, int c3, bit chg);
    logic [31:0] w;
    w = 32'hA53F_0000;            // noise outside the fields (R4)
    w[22]    = chg;
    w[3:0]   = 4'(c0);
    w[7:4]   = 4'(c1);
    w[11:8]  = 4'(c2);
    w[15:12] = 4'(c3);
    return w;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural reference model
  int m_cnt [4];
  int m_ratio [4];
  int m_code [4];
  bit m_chg;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin m_cnt[i] = 0; m_ratio[i] = 1; m_code[i] = 0; end
      m_chg = 0;
    end else begin
      for (int i = 0; i < 4; i++) begin
        if (m_cnt[i] == m_ratio[i] - 1) begin
          m_cnt[i] = 0;
          if (m_chg) m_ratio[i] = ref_ratio(m_code[i]);
        end else m_cnt[i]++;
      end
      if (cfg_wr) begin
        for (int i = 0; i < 4; i++) m_code[i] = int'(cfg_wdata[4*i +: 4]);
        m_chg = cfg_wdata[22];
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      for (int i = 0; i < 4; i++) begin
        bit es, ec;
        es = (m_cnt[i] == m_ratio[i] - 1);
        ec = (m_ratio[i] % 2 == 1) ? es : (m_cnt[i] < m_ratio[i] / 2);
        chk(div_stb[i] == es, "R7 strobe", int'(div_stb[i]), int'(es));
        if (m_ratio[i] % 2 == 1)
          chk(div_clk[i] == ec, "R9 odd clock", int'(div_clk[i]), int'(ec));
        else
          chk(div_clk[i] == ec, "R8 even clock", int'(div_clk[i]), int'(ec));
      end
    end
  end

  task automatic write_cfg(logic [31:0] w);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = w;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_wdata = '0;
  endtask

  task automatic period(int ch, output int p);
    do @(negedge clk); while (!div_stb[ch]);
    p = 0;
    do begin @(negedge clk); p++; end while (!div_stb[ch]);
  endtask

  task automatic apply_and_measure(int c0, int c1, int c2, int c3, string req);
    int c [4];
    int p;
    c = '{c0, c1, c2, c3};
    write_cfg(make_word(c0, c1, c2, c3, 1'b1));
    for (int i = 0; i < 4; i++) begin
      period(i, p);
      period(i, p);
      chk(p == ref_ratio(c[i]), req, p, ref_ratio(c[i]));
    end
  endtask

  initial begin
    int p;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(div_stb == 4'hF, "R1 strobes in reset", int'(div_stb), 15);
    chk(div_clk == 4'hF, "R1 clocks in reset", int'(div_clk), 15);
    rst_n = 1'b1;
    cmp_on = 1;
    repeat (5) @(negedge clk);
    chk(div_stb == 4'hF, "R1 strobes after reset", int'(div_stb), 15);
    chk(div_clk == 4'hF, "R1 clocks after reset", int'(div_clk), 15);

    // R5: codes written with change-enable clear stay pending
    write_cfg(make_word(1, 2, 3, 5, 1'b0));
    repeat (40) @(negedge clk);
    chk(div_stb == 4'hF, "R5 pending codes", int'(div_stb), 15);
    period(3, p);
    chk(p == 1, "R5 pending period", p, 1);

    // R2 and R4: distinct codes per field
    apply_and_measure(1, 2, 3, 5, "R2/R4 period");
    apply_and_measure(4, 6, 7, 8, "R2/R4 period");
    apply_and_measure(9, 0, 2, 3, "R2 period");
    // R3: clamped codes
    apply_and_measure(10, 15, 12, 9, "R3 clamp period");

    // R6: mid-period change; the period in flight keeps its old length
    apply_and_measure(0, 0, 0, 9, "R6 setup period");
    do @(negedge clk); while (!div_stb[3]);
    cfg_wr = 1'b1; cfg_wdata = make_word(0, 0, 0, 0, 1'b1);
    @(negedge clk);
    cfg_wr = 1'b0; cfg_wdata = '0;
    p = 1;
    while (!div_stb[3]) begin @(negedge clk); p++; end
    chk(p == 32, "R6 old period completes", p, 32);
    @(negedge clk);
    chk(div_stb[3] == 1'b1, "R6 new ratio after boundary", int'(div_stb[3]), 1);

    repeat (10) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule